// File: doc/BRIEF.md
# Bus address coverage bitmap

This block observes the address bus of a foreign processor together with its active-low strobe. Each high-to-low transition of the strobe records the address seen at that moment as a single set bit in an on-chip bitmap. The bitmap holds one flag per address. A host processor later reads these flags back as packed words through a small memory-mapped slave port.

The same slave port holds a handful of registers. They select the operating mode, set an interrupt threshold, report the running capture total and the interrupt status, start a bulk clear of the bitmap, and drive a debug LED output. A level interrupt is raised each time the programmed number of captures has accumulated. One mode bit decides whether the bitmap belongs to the capture side or to the host, so no arbitration is needed.

The default address width is 12 bits, which keeps the storage small. Setting `ADDR_W` to 18 covers the full 0x00000 to 0x3FFFF space.

Top module: `addr_cov_map`

## Requirements
- R1: After reset the control, capture-total, status and LED registers read zero, `irq_o` is low and `led_o` is zero.
- R2: When capture is enabled (control bit 0 = 1), a falling edge on `strobe_n_i` sets the bitmap flag for the sampled address A. That flag is bit A mod MAP_W of the word at bitmap-window index A / MAP_W. The bitmap window is host addresses with the top address bit set.
- R3: Captures only ever set flags: flags accumulate across captures, and a repeated address keeps its flag set. A strobe held low produces exactly one capture.
- R4: With control bit 0 = 0, strobe edges are ignored: the capture total and the bitmap do not change.
- R5: While capture is enabled, host reads of the bitmap window return zero. While capture is disabled, they return the stored word, zero-extended to 32 bits.
- R6: The capture total at register offset 2 increases by exactly one per capture. Host writes to it have no effect.
- R7: After every N captures, where N is the threshold at offset 1, status bit 0 (offset 3) is set. `irq_o` equals status bit 0 AND control bit 2.
- R8: Status bit 0 stays set until the host writes 1 to status bit 0. The count toward the next interrupt restarts at zero when the interrupt is raised.
- R9: Writing control bit 1 = 1 zeroes every bitmap word. Status bit 1 reads 1 while the clear runs, and strobes arriving during the clear are ignored.
- R10: A write to offset 4 sets `led_o` to the low LED_W data bits, and the value reads back from offset 4.
- R11: Read data appears on `h_rdata_o` on the cycle after `h_rd_i` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n_i | input | 1 | Monitored bus strobe, active low, asynchronous |
| bus_addr_i | input | ADDR_W | Monitored bus address, asynchronous |
| h_wr_i | input | 1 | Host write request |
| h_rd_i | input | 1 | Host read request |
| h_addr_i | input | WAW+1 | Host word address; top bit selects the bitmap window |
| h_wdata_i | input | 32 | Host write data |
| h_rdata_o | output | 32 | Host read data, one cycle after the read |
| irq_o | output | 1 | Level interrupt |
| led_o | output | LED_W | Debug LED output |

## Verification
The assertions assume that the monitored address is held steady from at least three clocks before the strobe falls until after it rises. This gives the two-flop address synchroniser a settled value when the edge is detected. They also assume the host issues at most one request per cycle and never reads and writes together. The stimulus meets these assumptions: it sets the address, waits, and only then pulls the strobe low for several clocks. Every host access is a single isolated cycle, and bitmap reads happen only after capture has been switched off.

// File: rtl/cov_pkg.sv
package cov_pkg;

    // Register offsets inside the control window (top host address bit = 0)
    typedef enum logic [2:0] {
        OFF_CTRL = 3'd0,
        OFF_THR  = 3'd1,
        OFF_CNT  = 3'd2,
        OFF_STS  = 3'd3,
        OFF_LED  = 3'd4
    } reg_off_e;

    typedef struct packed {
        logic irq_en;   // bit 2
        logic cap_en;   // bit 0
    } ctrl_t;

    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_MAP = 1'b1
    } rd_src_e;

    localparam int HOST_DW = 32;

    function automatic logic width_ok(input int w);
        return (w == 8) || (w == 16) || (w == 32);
    endfunction

endpackage

// File: rtl/cov_sync.sv
module cov_sync #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic          arm_i,
    output logic          fire_o,
    output logic [AW-1:0] addr_o
);
    logic          s1, s2, s3;
    logic [AW-1:0] a1, a2;
    logic          fall;

    assign fall = s3 & ~s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            s3     <= 1'b1;
            a1     <= '0;
            a2     <= '0;
            fire_o <= 1'b0;
            addr_o <= '0;
        end else begin
            s1     <= strobe_n_i;
            s2     <= s1;
            s3     <= s2;
            a1     <= addr_i;
            a2     <= a1;
            fire_o <= fall & arm_i;
            if (fall) addr_o <= a2;
        end
    end
endmodule

// File: rtl/cov_store.sv
module cov_store #(
    parameter int AW = 12,
    parameter int MW = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          set_i,
    input  logic [AW-1:0]                 set_addr_i,
    input  logic                          clr_start_i,
    output logic                          busy_o,
    input  logic                          rd_en_i,
    input  logic [AW-$clog2(MW)-1:0]      rd_idx_i,
    output logic [MW-1:0]                 rd_word_o
);
    localparam int LB    = $clog2(MW);
    localparam int WAW   = AW - LB;
    localparam int DEPTH = 1 << WAW;

    logic [MW-1:0]  mem [DEPTH];
    logic [WAW-1:0] walk;
    logic [WAW-1:0] set_w;
    logic [LB-1:0]  set_b;

    assign set_w = set_addr_i[AW-1:LB];
    assign set_b = set_addr_i[LB-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            walk   <= '0;
        end else if (busy_o) begin
            if (walk == WAW'(DEPTH - 1)) busy_o <= 1'b0;
            walk <= walk + 1'b1;
        end else if (clr_start_i) begin
            busy_o <= 1'b1;
            walk   <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (busy_o)     mem[walk]         <= '0;
        else if (set_i) mem[set_w][set_b] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_word_o <= '0;
        else if (rd_en_i) rd_word_o <= mem[rd_idx_i];
    end
endmodule

// File: rtl/cov_regs.sv
module cov_regs
    import cov_pkg::*;
#(
    parameter int WAW   = 9,
    parameter int MW    = 8,
    parameter int CNT_W = 16,
    parameter int LED_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_wr_i,
    input  logic               h_rd_i,
    input  logic [WAW:0]       h_addr_i,
    input  logic [HOST_DW-1:0] h_wdata_i,
    output logic [HOST_DW-1:0] h_rdata_o,
    input  logic               fire_i,
    input  logic               busy_i,
    input  logic [MW-1:0]      map_word_i,
    output logic               map_rd_o,
    output logic [WAW-1:0]     map_idx_o,
    output logic               clr_start_o,
    output logic               cap_en_o,
    output logic               irq_o,
    output logic               sts_o,
    output logic [31:0]        cnt_o,
    output logic [LED_W-1:0]   led_o
);
    ctrl_t              ctrl;
    logic [CNT_W-1:0]   thr;
    logic [CNT_W-1:0]   run;
    logic [HOST_DW-1:0] rd_reg_q;
    rd_src_e            src_q;
    logic               win;
    reg_off_e           off;
    logic [HOST_DW-1:0] reg_val;
    logic [CNT_W:0]     run_nx;

    assign win         = h_addr_i[WAW];
    assign off         = reg_off_e'(h_addr_i[2:0]);
    assign map_idx_o   = h_addr_i[WAW-1:0];
    assign map_rd_o    = h_rd_i & win & ~ctrl.cap_en;
    assign clr_start_o = h_wr_i & ~win & (off == OFF_CTRL) & h_wdata_i[1];
    assign cap_en_o    = ctrl.cap_en;
    assign irq_o       = sts_o & ctrl.irq_en;
    assign run_nx      = {1'b0, run} + 1'b1;

    always_comb begin
        reg_val = '0;
        if (!(|h_addr_i[WAW-1:3])) begin
            unique case (off)
                OFF_CTRL: reg_val = {29'd0, ctrl.irq_en, 1'b0, ctrl.cap_en};
                OFF_THR:  reg_val = HOST_DW'(thr);
                OFF_CNT:  reg_val = cnt_o;
                OFF_STS:  reg_val = {30'd0, busy_i, sts_o};
                OFF_LED:  reg_val = HOST_DW'(led_o);
                default:  reg_val = '0;
            endcase
        end
    end

    // host register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            thr   <= '0;
            led_o <= '0;
        end else if (h_wr_i && !win && !(|h_addr_i[WAW-1:3])) begin
            case (off)
                OFF_CTRL: ctrl  <= '{irq_en: h_wdata_i[2], cap_en: h_wdata_i[0]};
                OFF_THR:  thr   <= h_wdata_i[CNT_W-1:0];
                OFF_LED:  led_o <= h_wdata_i[LED_W-1:0];
                default:  ;
            endcase
        end
    end

    // capture total, threshold counter, interrupt status
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            run   <= '0;
            sts_o <= 1'b0;
        end else begin
            if (h_wr_i && !win && off == OFF_STS && !(|h_addr_i[WAW-1:3]) && h_wdata_i[0])
                sts_o <= 1'b0;
            if (fire_i) begin
                cnt_o <= cnt_o + 1'b1;
                if (run_nx >= {1'b0, thr}) begin
                    run   <= '0;
                    sts_o <= 1'b1;
                end else begin
                    run <= run_nx[CNT_W-1:0];
                end
            end
        end
    end

    // read path
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_reg_q <= '0;
            src_q    <= SRC_REG;
        end else if (h_rd_i) begin
            src_q    <= map_rd_o ? SRC_MAP : SRC_REG;
            rd_reg_q <= win ? '0 : reg_val;
        end
    end

    assign h_rdata_o = (src_q == SRC_MAP) ? HOST_DW'(map_word_i) : rd_reg_q;
endmodule

// File: rtl/addr_cov_map.sv
module addr_cov_map
    import cov_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int MAP_W  = 8,
    parameter int CNT_W  = 16,
    parameter int LED_W  = 8,
    localparam int WAW   = ADDR_W - $clog2(MAP_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe_n_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               h_wr_i,
    input  logic               h_rd_i,
    input  logic [WAW:0]       h_addr_i,
    input  logic [31:0]        h_wdata_i,
    output logic [31:0]        h_rdata_o,
    output logic               irq_o,
    output logic [LED_W-1:0]   led_o
);
    generate
        if (!width_ok(MAP_W)) begin : g_bad_width
            $error("MAP_W must be 8, 16 or 32");
        end
    endgenerate

    logic              fire, busy, clr_start, cap_en, map_rd, sts;
    logic [ADDR_W-1:0] cap_addr;
    logic [WAW-1:0]    map_idx;
    logic [MAP_W-1:0]  map_word;
    logic [31:0]       cnt;

    cov_sync #(.AW(ADDR_W)) u_sync (
        .clk(clk), .rst(rst),
        .strobe_n_i(strobe_n_i), .addr_i(bus_addr_i),
        .arm_i(cap_en & ~busy),
        .fire_o(fire), .addr_o(cap_addr)
    );

    cov_store #(.AW(ADDR_W), .MW(MAP_W)) u_store (
        .clk(clk), .rst(rst),
        .set_i(fire), .set_addr_i(cap_addr),
        .clr_start_i(clr_start), .busy_o(busy),
        .rd_en_i(map_rd), .rd_idx_i(map_idx), .rd_word_o(map_word)
    );

    cov_regs #(.WAW(WAW), .MW(MAP_W), .CNT_W(CNT_W), .LED_W(LED_W)) u_regs (
        .clk(clk), .rst(rst),
        .h_wr_i(h_wr_i), .h_rd_i(h_rd_i), .h_addr_i(h_addr_i),
        .h_wdata_i(h_wdata_i), .h_rdata_o(h_rdata_o),
        .fire_i(fire), .busy_i(busy), .map_word_i(map_word),
        .map_rd_o(map_rd), .map_idx_o(map_idx),
        .clr_start_o(clr_start), .cap_en_o(cap_en),
        .irq_o(irq_o), .sts_o(sts), .cnt_o(cnt), .led_o(led_o)
    );
endmodule

// File: rtl/addr_cov_map_chk.sv
module addr_cov_map_chk #(
    parameter int WAW   = 9,
    parameter int LED_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             fire,
    input logic             busy,
    input logic             sts,
    input logic [31:0]      cnt,
    input logic             h_wr_i,
    input logic [WAW:0]     h_addr_i,
    input logic [31:0]      h_wdata_i,
    input logic [LED_W-1:0] led_o
);
    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> cnt == $past(cnt) + 32'd1);
    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(cnt));
    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts) |-> $past(fire));
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sts && !(h_wr_i && h_addr_i == (WAW+1)'(3) && h_wdata_i[0])) |=> sts);
    // R9
    clr_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(h_wr_i && h_addr_i == '0 && h_wdata_i[1]));
    // R10
    led_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(h_wr_i && h_addr_i == (WAW+1)'(4)) |=> $stable(led_o));
endmodule

bind addr_cov_map addr_cov_map_chk #(.WAW(WAW), .LED_W(LED_W)) u_chk (
    .clk(clk), .rst(rst), .fire(fire), .busy(busy), .sts(sts), .cnt(cnt),
    .h_wr_i(h_wr_i), .h_addr_i(h_addr_i), .h_wdata_i(h_wdata_i), .led_o(led_o)
);

// File: tb/sim_addr_cov_map.sv
`timescale 1ns/1ps
module sim_addr_cov_map;
    localparam int AW  = 12;
    localparam int WAW = 9;
    localparam logic [WAW:0] WIN = 10'h200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_n = 1'b1;
    logic [AW-1:0] baddr = '0;
    logic          h_wr = 1'b0, h_rd = 1'b0;
    logic [WAW:0]  h_addr = '0;
    logic [31:0]   h_wdata = '0;
    logic [31:0]   h_rdata;
    logic          irq;
    logic [7:0]    led;

    int checks = 0;
    int errors = 0;

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t q[$];
    logic rd_q1 = 1'b0;

    always #4 clk = ~clk;

    addr_cov_map u0 (
        .clk(clk), .rst(rst), .strobe_n_i(strobe_n), .bus_addr_i(baddr),
        .h_wr_i(h_wr), .h_rd_i(h_rd), .h_addr_i(h_addr), .h_wdata_i(h_wdata),
        .h_rdata_o(h_rdata), .irq_o(irq), .led_o(led)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: result is valid at the negedge after the read edge
    always @(posedge clk) rd_q1 <= h_rd;
    always @(negedge clk) begin
        if (rd_q1 && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(h_rdata, e.exp, e.tag);
        end
    end

    task automatic hwr(input logic [WAW:0] a, input logic [31:0] d);
        @(negedge clk);
        h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic hrd(input logic [WAW:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        h_rd = 1'b1; h_addr = a;
        e.exp = exp; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        h_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe(input logic [AW-1:0] a, input int low_cycles);
        @(negedge clk);
        baddr = a;
        repeat (4) @(negedge clk);
        strobe_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        strobe_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        hrd(10'd0, 32'd0, "R1 ctrl");
        hrd(10'd2, 32'd0, "R1 count");
        hrd(10'd3, 32'd0, "R1 status");
        hrd(10'd4, 32'd0, "R1 led reg");
        check({31'd0, irq}, 32'd0, "R1 irq");
        check({24'd0, led}, 32'd0, "R1 led pin");

        // R9 clear with busy indication
        hwr(10'd0, 32'h2);
        hrd(10'd3, 32'h2, "R9 busy");
        repeat (600) @(negedge clk);
        hrd(10'd3, 32'h0, "R9 done");

        // R7 threshold 3, capture + irq enabled
        hwr(10'd1, 32'd3);
        hwr(10'd0, 32'h5);
        strobe(12'h005, 4);
        strobe(12'h005, 4);
        strobe(12'h123, 4);
        hrd(10'd2, 32'd3, "R6 count after 3");
        hrd(10'd3, 32'h1, "R7 status after N");
        check({31'd0, irq}, 32'd1, "R7 irq high");
        // R5 map reads blocked in capture mode
        hrd(WIN | 10'd0, 32'd0, "R5 masked read");

        // switch to host access
        hwr(10'd0, 32'h4);
        hrd(WIN | 10'd0, 32'h20, "R2 word0 bit5");
        hrd(WIN | 10'd36, 32'h08, "R2 word36 bit3");
        // R4 disabled strobe ignored
        strobe(12'h7FF, 4);
        hrd(10'd2, 32'd3, "R4 count unchanged");
        hrd(WIN | 10'd255, 32'd0, "R4 map unchanged");
        // R6 write to count ignored
        hwr(10'd2, 32'h55);
        hrd(10'd2, 32'd3, "R6 read-only count");
        // R8 hold then W1C
        hrd(10'd3, 32'h1, "R8 status held");
        hwr(10'd3, 32'h1);
        hrd(10'd3, 32'h0, "R8 status cleared");
        check({31'd0, irq}, 32'd0, "R8 irq low");

        // R8 restart of threshold count
        hwr(10'd0, 32'h5);
        strobe(12'h001, 4);
        strobe(12'h002, 4);
        hrd(10'd3, 32'h0, "R8 no irq after 2");
        strobe(12'hFFF, 4);
        hrd(10'd3, 32'h1, "R8 irq after 3rd");
        hwr(10'd0, 32'h1);
        check({31'd0, irq}, 32'd0, "R7 irq masked");
        // R3 long low strobe counts once
        strobe(12'h003, 25);
        hrd(10'd2, 32'd7, "R3 single capture");
        hwr(10'd0, 32'h0);
        hrd(WIN | 10'd0, 32'h2E, "R3 accumulated word0");

        // R9 clear with strobe during walk
        hwr(10'd0, 32'h3);
        strobe(12'h010, 4);
        repeat (600) @(negedge clk);
        hrd(10'd2, 32'd7, "R9 strobe ignored");
        hwr(10'd0, 32'h0);
        hrd(WIN | 10'd0, 32'h0, "R9 word0 zero");
        hrd(WIN | 10'd2, 32'h0, "R9 word2 zero");
        hrd(WIN | 10'd511, 32'h0, "R9 word511 zero");

        // R10 LED output
        hwr(10'd4, 32'hA5);
        check({24'd0, led}, 32'hA5, "R10 led pin");
        hrd(10'd4, 32'hA5, "R10 R11 led readback");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule